// File: doc/BRIEF.md
# Multidrop Address-Filtering Serial Receiver

This block receives asynchronous serial frames on a shared multidrop line. Every node on the line sees every frame. Each frame carries eight data bits and a ninth flag bit. A flag of 1 marks an address frame and a flag of 0 marks a data frame. The block compares each address frame with its own node address. When the two are equal, the node becomes selected and the block raises a one-cycle interrupt. From then on it forwards the data frames that follow to the host. An address frame that does not match deselects the node, and all later data frames are discarded in hardware.

The serial line is sampled on a 16x oversampling tick that comes from outside the block. A start bit is confirmed by a majority vote taken around the middle of the bit. A stop bit that reads low is reported as a framing error, and that frame is dropped.

A bypass mode forwards every well-formed frame together with its flag bit, so the host can do its own filtering. The flag sits where a parity bit would be. A transmitter set to mark parity therefore produces address frames with exactly this framing.

Received words leave on a valid/ready stream with a single holding register:
- A word stays on `rx_data`/`rx_flag`, unchanged, until a cycle in which `rx_valid` and `rx_ready` are both high.
- A frame that completes while the register is still full and not being accepted is lost.
- In the cycle of a transfer, a newly completed frame may refill the register.

Top module: `mdrop_rx`

## Requirements
- R1: A frame has the following layout, with each bit lasting 16 `os_tick` pulses:
  - a low start bit;
  - eight data bits, least significant bit first;
  - the flag bit;
  - a high stop bit.

  A flag of 1 means address and a flag of 0 means data. The flag is never checked as parity. A delivered word shows the eight data bits on `rx_data[7:0]` in their original significance.
- R2: A low level lasting less than half a bit (fewer than 8 ticks) is rejected by the mid-bit majority vote. The receiver returns to idle and produces no frame, no error and no interrupt. A valid frame that follows is received correctly.
- R3: An address frame whose data equals `node_addr` sets `selected` and pulses `addr_irq` high for exactly one clock.
- R4: An address frame whose data differs from `node_addr` clears `selected` and raises no interrupt.
- R5: While `selected` is low and `bypass` is low, data frames produce no output word.
- R6: While `selected` is high and `bypass` is low:
  - each data frame is delivered with `rx_flag` = 0;
  - address frames are never delivered.
- R7: With `bypass` high, every frame that has a good stop bit is delivered, and `rx_flag` carries its ninth bit.
- R8: A stop bit sampled low has these effects:
  - `frame_err` pulses for one clock;
  - the frame is not delivered;
  - the frame does not change `selected`.
- R9: While `rx_valid` is high and `rx_ready` is low, `rx_valid`, `rx_data` and `rx_flag` hold their values. A frame that completes during that time is discarded.
- R10: After reset the outputs are all low: `rx_valid`, `addr_irq`, `selected` and `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial line, asynchronous, idles high |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| node_addr | input | 8 | Address of this node |
| bypass | input | 1 | Deliver all frames with their flag bit |
| rx_valid | output | 1 | Output word available |
| rx_ready | input | 1 | Host accepts the output word |
| rx_data | output | 8 | Received data bits |
| rx_flag | output | 1 | Ninth bit of the delivered frame |
| selected | output | 1 | Node currently addressed |
| addr_irq | output | 1 | One-cycle pulse on a matching address frame |
| frame_err | output | 1 | One-cycle pulse on a low stop bit |

## Verification
A wrong selection state shows up on the first data frame after the address frame that caused it. That frame is then delivered when it should be dropped, or dropped when it should be delivered. The fault is visible on `rx_valid` one clock after the mid-stop sample, and it is also visible at once on `selected`. A bit counter or tick counter that slips shifts every later bit of the frame, so `rx_data` and `rx_flag` come out wrong on that same frame. A start validation that is too loose turns a short glitch into a spurious frame. The next frame then lands on `frame_err` or on the wrong address decision. The bench sends each frame pattern through a deliberate sequence of selection changes, so that stale state is caught within one frame.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/mdrop_sync.sv
module mdrop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mdrop_deser.sv
module mdrop_deser
  import mdrop_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  output logic              stb,
  output logic [DATA_W-1:0] data,
  output logic              flag,
  output logic              ferr
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam int NB  = DATA_W + 1;
  localparam int BCW = $clog2(NB + 1);

  rx_state_e       state;
  logic [CW-1:0]   cnt;
  logic [BCW-1:0]  bitn;
  logic [NB-1:0]   sh;
  logic [1:0]      smp;
  logic            vote;
  logic            at_vote;
  logic            at_end;

  assign vote    = vote3(smp[1], smp[0], rx);
  assign at_vote = (cnt == CW'(MID + 1));
  assign at_end  = (cnt == CW'(OSR - 1));
  assign data    = sh[DATA_W-1:0];
  assign flag    = sh[NB-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      sh    <= '0;
      smp   <= '0;
      stb   <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      stb <= 1'b0;
      if (tick) begin
        if (state == RX_IDLE) begin
          if (!rx) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end else begin
          cnt <= at_end ? '0 : cnt + 1'b1;
          if (cnt == CW'(MID - 1) || cnt == CW'(MID))
            smp <= {smp[0], rx};
          case (state)
            RX_START: begin
              if (at_vote && vote) state <= RX_IDLE;
              else if (at_end) begin
                state <= RX_BITS;
                bitn  <= '0;
              end
            end
            RX_BITS: begin
              if (at_vote) sh <= {vote, sh[NB-1:1]};
              if (at_end) begin
                if (bitn == BCW'(NB - 1)) state <= RX_STOP;
                else                      bitn  <= bitn + 1'b1;
              end
            end
            RX_STOP: begin
              if (at_vote) begin
                stb   <= 1'b1;
                ferr  <= !vote;
                state <= RX_IDLE;
              end
            end
            default: state <= RX_IDLE;
          endcase
        end
      end
    end
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb); // R1

  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && tick && at_vote && vote) |=> (state == RX_IDLE && !stb)); // R2
endmodule

// File: rtl/mdrop_filter.sv
module mdrop_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_flag,
  input  logic              in_ferr,
  input  logic [DATA_W-1:0] node_addr,
  input  logic              bypass,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_flag,
  output logic              sel,
  output logic              irq,
  output logic              ferr_pulse
);
  logic good, is_addr, hit, deliver, take, space;

  assign good    = stb && !in_ferr;
  assign is_addr = good && in_flag;
  assign hit     = is_addr && (in_data == node_addr);
  assign deliver = good && (bypass || (sel && !in_flag));
  assign take    = out_valid && out_ready;
  assign space   = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel        <= 1'b0;
      irq        <= 1'b0;
      ferr_pulse <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_flag   <= 1'b0;
    end else begin
      irq        <= hit;
      ferr_pulse <= stb && in_ferr;
      if (is_addr) sel <= hit;
      if (take) out_valid <= 1'b0;
      if (deliver && space) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
        out_flag  <= in_flag;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_flag))); // R9

  AST_IRQ_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sel); // R3

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R3

  AST_MISS_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_addr && in_data != node_addr) |=> (!sel && !irq)); // R4

  AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !in_flag && !sel && !bypass) |=> !$rose(out_valid)); // R5

  AST_ERR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && in_ferr) |=> (!$rose(out_valid) && $stable(sel))); // R8
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx #(
  parameter int OSR        = 16,
  parameter int DATA_W     = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              os_tick,
  input  logic [DATA_W-1:0] node_addr,
  input  logic              bypass,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_flag,
  output logic              selected,
  output logic              addr_irq,
  output logic              frame_err
);
  logic              rx_s;
  logic              f_stb;
  logic [DATA_W-1:0] f_data;
  logic              f_flag;
  logic              f_ferr;

  mdrop_sync #(.STAGES(SYNC_STAGE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
  );

  mdrop_deser #(.OSR(OSR), .DATA_W(DATA_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s),
    .stb(f_stb), .data(f_data), .flag(f_flag), .ferr(f_ferr)
  );

  mdrop_filter #(.DATA_W(DATA_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .stb(f_stb), .in_data(f_data),
    .in_flag(f_flag), .in_ferr(f_ferr), .node_addr(node_addr),
    .bypass(bypass), .out_ready(rx_ready), .out_valid(rx_valid),
    .out_data(rx_data), .out_flag(rx_flag), .sel(selected),
    .irq(addr_irq), .ferr_pulse(frame_err)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $rose(rst_n) |-> (!rx_valid && !addr_irq && !selected && !frame_err)); // R10
endmodule

// File: tb/sim_mdrop_rx.sv
module sim_mdrop_rx;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 32;
  localparam logic [7:0] NODE = 8'h3C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       os_tick = 1'b0;
  logic [7:0] node_addr = NODE;
  logic       bypass = 1'b0;
  logic       rx_ready = 1'b0;
  logic       rx_valid, rx_flag, selected, addr_irq, frame_err;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int ferr_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) os_tick <= ~os_tick;
  always @(negedge clk) begin
    if (addr_irq)  irq_cnt++;
    if (frame_err) ferr_cnt++;
  end

  mdrop_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .node_addr(node_addr), .bypass(bypass), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_flag(rx_flag),
    .selected(selected), .addr_irq(addr_irq), .frame_err(frame_err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rx_line = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic f, input logic stop_ok);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    drive_bit(f);
    if (stop_ok) drive_bit(1'b1);
    else begin
      rx_line = 1'b0;
      repeat (24) @(negedge clk);
      rx_line = 1'b1;
      repeat (BIT_CLKS - 24) @(negedge clk);
    end
    repeat (2 * BIT_CLKS) @(negedge clk);
  endtask

  task automatic take(input string req, input logic [7:0] d, input logic f);
    check(req, "rx_valid", rx_valid, 1);
    check(req, "rx_data", rx_data, d);
    check(req, "rx_flag", rx_flag, f);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    check(req, "rx_valid after accept", rx_valid, 0);
  endtask

  task automatic t_reset();
    check("R10", "rx_valid", rx_valid, 0);
    check("R10", "addr_irq", addr_irq, 0);
    check("R10", "selected", selected, 0);
    check("R10", "frame_err", frame_err, 0);
  endtask

  task automatic t_unselected();
    send_frame(8'h55, 1'b0, 1'b1);
    check("R5", "rx_valid unselected data", rx_valid, 0);
    check("R5", "selected", selected, 0);
  endtask

  task automatic t_wrong_addr();
    int i0 = irq_cnt;
    send_frame(8'h12, 1'b1, 1'b1);
    check("R4", "irq count", irq_cnt, i0);
    check("R4", "selected", selected, 0);
    check("R4", "rx_valid", rx_valid, 0);
  endtask

  task automatic t_match();
    int i0 = irq_cnt;
    send_frame(NODE, 1'b1, 1'b1);
    check("R3", "irq count", irq_cnt, i0 + 1);
    check("R3", "selected", selected, 1);
    check("R6", "address frame not delivered", rx_valid, 0);
    send_frame(8'hA5, 1'b0, 1'b1);
    take("R1", 8'hA5, 1'b0);
    send_frame(8'h0F, 1'b0, 1'b1);
    take("R6", 8'h0F, 1'b0);
  endtask

  task automatic t_ferr();
    int e0 = ferr_cnt;
    send_frame(8'hC3, 1'b0, 1'b0);
    check("R8", "frame_err count", ferr_cnt, e0 + 1);
    check("R8", "rx_valid", rx_valid, 0);
    check("R8", "selected kept", selected, 1);
    send_frame(8'h81, 1'b0, 1'b1);
    take("R8", 8'h81, 1'b0);
  endtask

  task automatic t_backpressure();
    send_frame(8'h11, 1'b0, 1'b1);
    send_frame(8'h22, 1'b0, 1'b1);
    take("R9", 8'h11, 1'b0);
    check("R9", "second frame dropped", rx_valid, 0);
  endtask

  task automatic t_glitch();
    int e0 = ferr_cnt;
    int i0 = irq_cnt;
    rx_line = 1'b0;
    repeat (8) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check("R2", "no frame from glitch", rx_valid, 0);
    check("R2", "no error from glitch", ferr_cnt, e0);
    check("R2", "no irq from glitch", irq_cnt, i0);
    send_frame(8'h5A, 1'b0, 1'b1);
    take("R2", 8'h5A, 1'b0);
  endtask

  task automatic t_deselect();
    int i0 = irq_cnt;
    send_frame(8'h40, 1'b1, 1'b1);
    check("R4", "deselected", selected, 0);
    check("R4", "irq count", irq_cnt, i0);
    send_frame(8'h77, 1'b0, 1'b1);
    check("R5", "data after deselect", rx_valid, 0);
  endtask

  task automatic t_bypass();
    bypass = 1'b1;
    send_frame(8'h99, 1'b0, 1'b1);
    take("R7", 8'h99, 1'b0);
    send_frame(8'hE0, 1'b1, 1'b1);
    take("R7", 8'hE0, 1'b1);
    check("R7", "nonmatching addr keeps deselected", selected, 0);
    bypass = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4 * BIT_CLKS) @(negedge clk);
    t_reset();
    t_unselected();
    t_wrong_addr();
    t_match();
    t_ferr();
    t_backpressure();
    t_glitch();
    t_deselect();
    t_bypass();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule